// File: doc/BRIEF.md
# DMA Sample Streamer

The block is a small register-programmed DMA engine that feeds a four-channel audio output path. Software programs a source address, a word count and a control word. The engine then runs by itself. Each time the serial transmitter signals a free word slot, the engine issues one memory read. The low 16 bits of the returned word go to the next of four output channels in turn.

The engine updates its source address and remaining count after each word. When the last word arrives it leaves the count at zero and the source register pointing just past the final word. It then raises an interrupt, which stays up until acknowledged. While the engine runs, the control word reports a two-bit running status. Software cancels a transfer by clearing the start field or the count. A cancelled transfer raises no interrupt.

Register map: offset 0 is control, offset 1 is source address, offset 2 is a destination address that is stored but not used, and offset 3 is the transfer count. Control bits [1:0] form the start field. Bits [3:2] are the running status and cannot be written. Bit 4 selects whether the address increments. All other bits are kept and read back as written.

Top module: `sample_dma_streamer`

## Requirements
- R1: The engine is running only while control bits [1:0] both equal 1 and the count register is nonzero. When it is not running, a slot strobe issues no memory read.
- R2: Reading control (offset 0) returns bits [3:2] as 2'b11 while running and 2'b00 while idle. Every other bit reads back as last written.
- R3: A slot strobe accepted while running raises `mem_req` for exactly one cycle, in the cycle after the strobe, with `mem_addr` equal to the current source register. Strobes that arrive while a read is outstanding are ignored.
- R4: After each delivered word, the source register advances by 1 when control bit 4 is 1 and stays the same when it is 0.
- R5: Each delivered word lowers the count by 1. When the last word is delivered, the count reads 0, the source reads the address after the last word, `dma_irq` rises in the same cycle as the last channel load, and the engine becomes idle.
- R6: Word k of a transfer (counting from 0 at each start) puts its low 16 bits on channel k mod 4, at `ch_data[16c +: 16]`. `ch_load` pulses one-hot for that channel in the cycle the new value appears.
- R7: `dma_irq` stays high until `irq_ack` is pulsed, and then goes low.
- R8: Clearing the start field or writing the count to zero while running stops the transfer. No interrupt is raised, later strobes issue no reads, the remaining count is kept, and a read still outstanding has its data discarded.
- R9: The destination register (offset 2) reads back as written and has no effect on the transfer.
- R10: After reset, all four registers read 0, and `dma_irq`, `mem_req`, `ch_load` and `ch_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| slot_strobe | input | 1 | Serial word slot is free |
| mem_req | output | 1 | Memory read request, one-cycle pulse |
| mem_addr | output | 24 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| ch_data | output | 64 | Four 16-bit channel samples, channel 0 in the low bits |
| ch_load | output | 4 | One-hot pulse marking the channel just loaded |
| dma_irq | output | 1 | Completion interrupt |
| irq_ack | input | 1 | Pulse high to clear the interrupt |

## Verification
`mem_req` is due one cycle after the edge that takes the strobe. The channel load, the source and count updates and the interrupt all come out of the edge that accepts `mem_rvalid`, so they are visible together in the following cycle. Status readback is combinational and follows a register write one edge later. The bench drives inputs and samples outputs on the falling edge. It checks the request in the cycle right after the strobe, then waits a bounded number of cycles for the single channel-load pulse, because memory latency varies from 0 to 2 extra cycles. Cancellation and ignore cases are checked by watching `mem_req`, `ch_load` and the readback over a fixed window.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int REG_DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_DST  = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  localparam int CTRL_START_LO = 0;
  localparam int CTRL_START_HI = 1;
  localparam int CTRL_STAT_LO  = 2;
  localparam int CTRL_STAT_HI  = 3;
  localparam int CTRL_INC_BIT  = 4;
endpackage

// File: rtl/dss_regs.sv
module dss_regs
  import dss_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            sel,
  input  logic [REG_DATA_W-1:0] wdata,
  output logic [REG_DATA_W-1:0] rdata,
  input  logic                  adv_i,
  output logic                  run_o,
  output logic [ADDR_W-1:0]     src_o,
  output logic [CNT_W-1:0]      cnt_o
);
  logic [REG_DATA_W-1:0] ctrl_q, ctrl_d;
  logic [ADDR_W-1:0]     src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [ADDR_W-1:0]     step;

  assign run_o = (ctrl_q[CTRL_START_HI:CTRL_START_LO] == 2'b11) && (cnt_q != '0);
  assign step  = {{(ADDR_W-1){1'b0}}, ctrl_q[CTRL_INC_BIT]};
  assign src_o = src_q;
  assign cnt_o = cnt_q;

  always_comb begin
    ctrl_d = ctrl_q;
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    if (adv_i) begin
      src_d = src_q + step;
      cnt_d = cnt_q - CNT_W'(1);
    end
    if (wr_en) begin
      unique case (reg_sel_e'(sel))
        SEL_CTRL: ctrl_d = wdata;
        SEL_SRC:  src_d  = wdata[ADDR_W-1:0];
        SEL_DST:  dst_d  = wdata[ADDR_W-1:0];
        SEL_CNT:  cnt_d  = wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(sel))
      SEL_CTRL: begin
        rdata = ctrl_q;
        rdata[CTRL_STAT_HI:CTRL_STAT_LO] = run_o ? 2'b11 : 2'b00;
      end
      SEL_SRC: rdata = REG_DATA_W'(src_q);
      SEL_DST: rdata = REG_DATA_W'(dst_q);
      SEL_CNT: rdata = REG_DATA_W'(cnt_q);
      default: rdata = '0;
    endcase
  end

  // each accepted word lowers the count by exactly one
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // the source moves by the increment bit, no more
  assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_en && !ctrl_q[CTRL_INC_BIT]) |=> $stable(src_q));
endmodule

// File: rtl/dss_fetch.sv
module dss_fetch #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              rvalid_i,
  input  logic              irq_ack_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              adv_o,
  output logic              irq_o
);
  logic              pend_q, pend_d;
  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              irq_q, irq_d;
  logic              launch, last_word;

  assign launch    = run_i && strobe_i && !pend_q;
  assign adv_o     = rvalid_i && pend_q && run_i;
  assign last_word = adv_o && (cnt_i == CNT_W'(1));

  always_comb begin
    pend_d = pend_q;
    if (!run_i)        pend_d = 1'b0;
    else if (launch)   pend_d = 1'b1;
    else if (rvalid_i) pend_d = 1'b0;
    req_d  = launch;
    addr_d = launch ? src_i : addr_q;
    irq_d  = irq_q;
    if (irq_ack_i) irq_d = 1'b0;
    if (last_word) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      addr_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
      addr_q <= addr_d;
      irq_q  <= irq_d;
    end
  end

  assign mem_req_o  = req_q;
  assign mem_addr_o = addr_q;
  assign irq_o      = irq_q;

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  assert_req_from_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) |-> $past(run_i));

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i) |=> irq_o);

  assert_irq_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(cnt_i) == CNT_W'(1)));
endmodule

// File: rtl/dss_chan.sv
module dss_chan #(
  parameter int NCH   = 4,
  parameter int SMP_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic                 adv_i,
  input  logic [SMP_W-1:0]     sample_i,
  output logic [NCH*SMP_W-1:0] ch_data_o,
  output logic [NCH-1:0]       ch_load_o
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [NCH-1:0]   load_q, load_d;

  always_comb begin
    idx_d = idx_q;
    if (!run_i)
      idx_d = '0;
    else if (adv_i)
      idx_d = (idx_q == IDX_W'(NCH-1)) ? '0 : idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      load_q <= '0;
    end else begin
      idx_q  <= idx_d;
      load_q <= load_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SMP_W-1:0] smp_q;
    logic             hit;
    assign hit       = adv_i && (idx_q == IDX_W'(c));
    assign load_d[c] = hit;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   smp_q <= '0;
      else if (hit) smp_q <= sample_i;
    end
    assign ch_data_o[c*SMP_W +: SMP_W] = smp_q;
  end

  assign ch_load_o = load_q;

  assert_load_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load_o));
endmodule

// File: rtl/sample_dma_streamer.sv
module sample_dma_streamer
  import dss_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int NCH    = 4,
  parameter int SMP_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_addr,
  input  logic [REG_DATA_W-1:0] cfg_wdata,
  output logic [REG_DATA_W-1:0] cfg_rdata,
  input  logic                  slot_strobe,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic                  mem_rvalid,
  input  logic [REG_DATA_W-1:0] mem_rdata,
  output logic [NCH*SMP_W-1:0]  ch_data,
  output logic [NCH-1:0]        ch_load,
  output logic                  dma_irq,
  input  logic                  irq_ack
);
  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic              run, adv;
  logic [ADDR_W-1:0] src;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  dss_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(cfg_wr), .sel(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .adv_i(adv),
    .run_o(run), .src_o(src), .cnt_o(cnt)
  );

  dss_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_s_n), .run_i(run), .strobe_i(slot_strobe),
    .src_i(src), .cnt_i(cnt), .rvalid_i(mem_rvalid), .irq_ack_i(irq_ack),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .adv_o(adv), .irq_o(dma_irq)
  );

  dss_chan #(.NCH(NCH), .SMP_W(SMP_W)) u_chan (
    .clk(clk), .rst_n(rst_s_n), .run_i(run), .adv_i(adv),
    .sample_i(mem_rdata[SMP_W-1:0]), .ch_data_o(ch_data), .ch_load_o(ch_load)
  );
endmodule

// File: tb/test_sample_dma_streamer.sv
module test_sample_dma_streamer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        slot_strobe = 1'b0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [63:0] ch_data;
  logic [3:0]  ch_load;
  logic        dma_irq;
  logic        irq_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  int forced_lat = -1;
  int req_seen = 0;

  always #5 clk = ~clk;

  sample_dma_streamer i_sample_dma_streamer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .slot_strobe(slot_strobe),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ch_data(ch_data), .ch_load(ch_load),
    .dma_irq(dma_irq), .irq_ack(irq_ack)
  );

  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {16'hA5A5 ^ a[15:0], a[15:0] * 16'd3 + 16'h1234};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one outstanding read, 0..2 extra cycles of latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        automatic logic [23:0] a = mem_addr;
        automatic int lat = (forced_lat >= 0) ? forced_lat : int'($urandom_range(0, 2));
        req_seen++;
        repeat (lat) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(a);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic strobe1();
    @(negedge clk);
    slot_strobe = 1'b1;
    @(negedge clk);
    slot_strobe = 1'b0;
  endtask

  // one word: strobe, check request, then wait for the channel load
  task automatic do_word(input logic [23:0] ea, input int ech);
    logic [3:0] got;
    strobe1();
    check(mem_req === 1'b1 && mem_addr === ea, "R3 request addr", {mem_req, mem_addr}, {1'b1, ea});
    got = '0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ch_load != 4'd0) begin
        got = ch_load;
        break;
      end
    end
    check(got == (4'd1 << ech), "R6 channel select", got, 4'd1 << ech);
    check(ch_data[ech*16 +: 16] == mem_word(ea)[15:0], "R6 channel sample",
          ch_data[ech*16 +: 16], mem_word(ea)[15:0]);
  endtask

  task automatic run_transfer(input logic [23:0] s, input int n, input bit inc);
    logic [31:0] cw, rv, expc;
    logic [23:0] ea;
    cw = $urandom();
    cw[1:0] = 2'b11;
    cw[4] = inc;
    wr(2'd1, {8'h0, s});
    wr(2'd3, n);
    wr(2'd0, cw);
    expc = cw; expc[3:2] = 2'b11;
    rd(2'd0, rv);
    check(rv == expc, "R2 status running", rv, expc);
    ea = s;
    for (int w = 0; w < n; w++) begin
      do_word(ea, w % 4);
      if (inc) ea = ea + 24'd1;
      if (w < n - 1) check(dma_irq == 1'b0, "R5 no irq before last", dma_irq, 0);
    end
    check(dma_irq == 1'b1, "R5 irq on last word", dma_irq, 1);
    rd(2'd3, rv);
    check(rv == 0, "R5 count zero", rv, 0);
    rd(2'd1, rv);
    check(rv == {8'h0, ea}, "R4 final source", rv, {8'h0, ea});
    rd(2'd0, rv);
    expc[3:2] = 2'b00;
    check(rv == expc, "R2 status idle", rv, expc);
    req_seen = 0;
    strobe1();
    repeat (4) @(negedge clk);
    check(req_seen == 0, "R1 idle after completion", req_seen, 0);
    check(dma_irq == 1'b1, "R7 irq held", dma_irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check(dma_irq == 1'b0, "R7 irq cleared by ack", dma_irq, 0);
  endtask

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), rv);
      check(rv == 0, "R10 register reset", rv, 0);
    end
    check(dma_irq == 0 && mem_req == 0 && ch_load == 0 && ch_data == 0,
          "R10 outputs reset", {dma_irq, mem_req, ch_load}, 0);

    // R9 destination stored, no effect
    wr(2'd2, 32'h00_808048);
    rd(2'd2, rv);
    check(rv == 32'h00_808048, "R9 dest readback", rv, 32'h00_808048);
    rd(2'd0, rv);
    check(rv[3:2] == 2'b00, "R9 dest leaves engine idle", rv[3:2], 0);

    // R1 start with zero count, and partial start field
    wr(2'd1, 32'h100);
    wr(2'd0, 32'h13);
    req_seen = 0;
    strobe1();
    repeat (4) @(negedge clk);
    check(req_seen == 0, "R1 zero count idle", req_seen, 0);
    wr(2'd0, 32'h11);
    wr(2'd3, 32'd4);
    strobe1();
    repeat (4) @(negedge clk);
    check(req_seen == 0, "R1 partial start idle", req_seen, 0);
    rd(2'd0, rv);
    check(rv == 32'h11, "R2 idle readback", rv, 32'h11);
    wr(2'd3, 32'd0);

    // directed transfers: fixed address, incrementing, single word
    run_transfer(24'h000200, 5, 1'b0);
    run_transfer(24'h00FFFE, 6, 1'b1);
    run_transfer(24'h000040, 1, 1'b1);

    // random transfers
    for (int t = 0; t < 8; t++)
      run_transfer(24'($urandom()), int'($urandom_range(1, 9)), 1'($urandom()));

    // R3 strobe held two cycles gives only one read
    wr(2'd1, 32'h300);
    wr(2'd3, 32'd3);
    wr(2'd0, 32'h13);
    forced_lat = 2;
    req_seen = 0;
    @(negedge clk); slot_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk); slot_strobe = 1'b0;
    repeat (6) @(negedge clk);
    check(req_seen == 1, "R3 strobe during pending ignored", req_seen, 1);
    rd(2'd3, rv);
    check(rv == 2, "R5 count after one word", rv, 2);

    // R8 cancel by clearing start field
    wr(2'd0, 32'h10);
    rd(2'd0, rv);
    check(rv == 32'h10, "R8 cancel status idle", rv, 32'h10);
    req_seen = 0;
    strobe1();
    repeat (4) @(negedge clk);
    check(req_seen == 0, "R8 no reads after cancel", req_seen, 0);
    rd(2'd3, rv);
    check(rv == 2, "R8 count kept", rv, 2);
    check(dma_irq == 0, "R8 no irq on cancel", dma_irq, 0);

    // R8 cancel by zero count with a read in flight
    wr(2'd1, 32'h400);
    wr(2'd3, 32'd4);
    wr(2'd0, 32'h13);
    forced_lat = 4;
    strobe1();
    wr(2'd3, 32'd0);
    begin
      logic [3:0] seen;
      seen = '0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        seen = seen | ch_load;
      end
      check(seen == 0, "R8 in-flight data discarded", seen, 0);
    end
    rd(2'd1, rv);
    check(rv == 32'h400, "R8 source unchanged", rv, 32'h400);
    check(dma_irq == 0, "R8 no irq after in-flight cancel", dma_irq, 0);
    forced_lat = -1;

    // restart after cancel begins on channel 0
    run_transfer(24'h000500, 3, 1'b1);

    summary();
  end
endmodule